// File: doc/BRIEF.md
# Register-Launched Block Copy Engine

This block copies a block of data between local DSP memory and a main memory that is addressed by bytes over a 32-bit address. Software programs it through a small set of 16-bit memory-mapped registers: a control word, a DSP-side word address, a main-memory byte address split into a high half and a low half, and a byte count. There is no separate start bit. A write to the byte-count register launches the copy.

The DSP side is 16 bits wide and is addressed by words. The main-memory side is 8 bits wide and is addressed by bytes. Each word therefore costs one DSP access and two main-memory accesses. The upper byte of a word always sits at the lower main-memory address.

Both memory ports use a single-beat request/acknowledge handshake. The engine issues one access at a time and holds it until the access is acknowledged. The address registers advance in place as words move, so after a copy they point just past the block. A one-cycle done pulse marks the end of every launched copy, including a copy of zero bytes.

Top module: `xfer_dma`

## Requirements
- R1: After reset, every register reads 0. No memory request is raised and done is 0.
- R2: The register map is as follows. 0xFFC9 is control: bit 0 is direction, bit 1 is DSP space, bit 2 is a read-only busy flag, and all other bits read 0. 0xFFCB is the byte count, which reads back the remaining bytes. 0xFFCD is the DSP word address. 0xFFCE holds main address bits 31..16 and 0xFFCF holds bits 15..0. Any other address reads 0 and accepts no write.
- R3: A non-zero write to the count register while idle starts a copy. The busy bit reads 1 from the cycle after that write until the copy ends, and memory requests appear only while busy.
- R4: With direction 0 (main to DSP), each word is assembled from the bytes at main addresses a and a+1, with the byte at a as bits 15..8. The word is written to the DSP address. The dsp_space pin equals control bit 1 (0 selects data space, 1 selects instruction space).
- R5: With direction 1 (DSP to main), each word is read from the DSP address. Bits 15..8 are written to main address a and bits 7..0 to a+1.
- R6: The byte count is rounded up to an even number: a count of N moves (N+1)/2 words, so an odd count moves one extra byte.
- R7: Each word advances the DSP address register by 1 and the 32-bit main address by 2, with the carry passing from the low half into the high half. At the end of a copy the count register reads 0.
- R8: Writing a count of 0 while idle makes no memory access, never sets busy, and raises done in the cycle right after the write.
- R9: Done is high for exactly one cycle, in the cycle after the last access is acknowledged. Busy reads 0 in that same cycle.
- R10: While busy, writes to every register are ignored. A further count write does not restart or extend the copy, and the direction, space and addresses keep their values.
- R11: At most one of mm_req and dsp_req is high at a time. A request keeps its address, write flag and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| dsp_req | output | 1 | DSP memory request |
| dsp_we | output | 1 | DSP memory write (1) or read (0) |
| dsp_space | output | 1 | DSP space select: 0 data, 1 instruction |
| dsp_addr | output | 16 | DSP word address |
| dsp_wdata | output | 16 | DSP write data |
| dsp_rdata | input | 16 | DSP read data, valid with dsp_ack |
| dsp_ack | input | 1 | DSP access complete |
| mm_req | output | 1 | Main memory request |
| mm_we | output | 1 | Main memory write (1) or read (0) |
| mm_addr | output | 32 | Main memory byte address |
| mm_wdata | output | 8 | Main memory write byte |
| mm_rdata | input | 8 | Main memory read byte, valid with mm_ack |
| mm_ack | input | 1 | Main memory access complete |
| done | output | 1 | One-cycle pulse when a launched copy ends |

## Verification
A wrong sequencer state shows at the memory ports within one access. It appears as a request on the wrong port, a write where a read was due, or two requests at once. A fault in the byte packing shows as swapped or stale bytes in the destination memory as soon as the first word lands.

An address or count that advances wrongly is only fully visible when the copy ends. It shows as destination words in the wrong place, a wrong number of accesses, a done pulse that comes too early or too late, or wrong end values when the address registers are read back. A busy guard that leaks lets a write issued in mid-copy change the registers read back after done, or change the access count.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned DSP_AW  = 16;
  localparam int unsigned MAIN_AW = 32;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LEN_W   = 16;

  localparam logic [REG_W-1:0] A_CTL  = 16'hFFC9;
  localparam logic [REG_W-1:0] A_LEN  = 16'hFFCB;
  localparam logic [REG_W-1:0] A_DSP  = 16'hFFCD;
  localparam logic [REG_W-1:0] A_MHI  = 16'hFFCE;
  localparam logic [REG_W-1:0] A_MLO  = 16'hFFCF;

  localparam int unsigned CTL_DIR_BIT  = 0;
  localparam int unsigned CTL_SPC_BIT  = 1;
  localparam int unsigned CTL_BUSY_BIT = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MRD_HI,
    S_MRD_LO,
    S_DWR,
    S_DRD,
    S_MWR_HI,
    S_MWR_LO
  } seq_state_e;

  function automatic logic [LEN_W-1:0] len_to_words(input logic [LEN_W-1:0] nbytes);
    logic [LEN_W:0] sum;
    sum = {1'b0, nbytes} + {{LEN_W{1'b0}}, 1'b1};
    return sum[LEN_W:1];
  endfunction

  function automatic logic [REG_W-1:0] words_to_bytes(input logic [LEN_W-1:0] words);
    return {words[LEN_W-2:0], 1'b0};
  endfunction

  function automatic logic [DSP_AW-1:0] next_dsp_addr(input logic [DSP_AW-1:0] a);
    return a + {{(DSP_AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [MAIN_AW-1:0] next_main_addr(input logic [MAIN_AW-1:0] a);
    return a + {{(MAIN_AW-2){1'b0}}, 2'd2};
  endfunction

  function automatic logic [MAIN_AW-1:0] byte_addr(input logic [MAIN_AW-1:0] a,
                                                   input logic lo);
    return a + {{(MAIN_AW-1){1'b0}}, lo};
  endfunction

endpackage

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               busy,
  input  logic               step,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               ctl_dir,
  output logic               ctl_space,
  output logic [DSP_AW-1:0]  dsp_addr,
  output logic [MAIN_AW-1:0] main_addr,
  output logic [LEN_W-1:0]   words,
  output logic               launch,
  output logic               launch_zero
);

  logic              wr_ok;
  logic [LEN_W-1:0]  new_words;
  logic              hit_len;

  assign wr_ok       = reg_we && !busy;
  assign hit_len     = wr_ok && (reg_addr == A_LEN);
  assign new_words   = len_to_words(reg_wdata);
  assign launch      = hit_len && (new_words != '0);
  assign launch_zero = hit_len && (new_words == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_dir   <= 1'b0;
      ctl_space <= 1'b0;
      dsp_addr  <= '0;
      main_addr <= '0;
      words     <= '0;
    end else if (step) begin
      dsp_addr  <= next_dsp_addr(dsp_addr);
      main_addr <= next_main_addr(main_addr);
      words     <= words - {{(LEN_W-1){1'b0}}, 1'b1};
    end else if (wr_ok) begin
      unique case (reg_addr)
        A_CTL: begin
          ctl_dir   <= reg_wdata[CTL_DIR_BIT];
          ctl_space <= reg_wdata[CTL_SPC_BIT];
        end
        A_LEN: words <= new_words;
        A_DSP: dsp_addr <= reg_wdata[DSP_AW-1:0];
        A_MHI: main_addr[MAIN_AW-1:REG_W] <= reg_wdata;
        A_MLO: main_addr[REG_W-1:0] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTL: begin
        reg_rdata[CTL_DIR_BIT]  = ctl_dir;
        reg_rdata[CTL_SPC_BIT]  = ctl_space;
        reg_rdata[CTL_BUSY_BIT] = busy;
      end
      A_LEN:   reg_rdata = words_to_bytes(words);
      A_DSP:   reg_rdata = dsp_addr;
      A_MHI:   reg_rdata = main_addr[MAIN_AW-1:REG_W];
      A_MLO:   reg_rdata = main_addr[REG_W-1:0];
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/xfer_dma_lane.sv
module xfer_dma_lane
  import xfer_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic              cap_word,
  input  logic              sel_lo,
  input  logic [BYTE_W-1:0] mm_rdata,
  input  logic [WORD_W-1:0] dsp_rdata,
  output logic [WORD_W-1:0] word_q,
  output logic [BYTE_W-1:0] byte_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (cap_word) begin
      word_q <= dsp_rdata;
    end else if (cap_hi) begin
      word_q[WORD_W-1:BYTE_W] <= mm_rdata;
    end else if (cap_lo) begin
      word_q[BYTE_W-1:0] <= mm_rdata;
    end
  end

  assign byte_out = sel_lo ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];

endmodule

// File: rtl/xfer_dma_seq.sv
module xfer_dma_seq
  import xfer_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_zero,
  input  logic             ctl_dir,
  input  logic [LEN_W-1:0] words,
  input  logic             dsp_ack,
  input  logic             mm_ack,
  output logic             busy,
  output logic             step,
  output logic             done,
  output logic             dsp_req,
  output logic             dsp_we,
  output logic             mm_req,
  output logic             mm_we,
  output logic             mm_lo,
  output logic             cap_hi,
  output logic             cap_lo,
  output logic             cap_word
);

  seq_state_e state_q, state_d;
  seq_state_e first_st;
  logic       done_d;
  logic       last_word;

  assign first_st  = ctl_dir ? S_DRD : S_MRD_HI;
  assign last_word = (words == {{(LEN_W-1){1'b0}}, 1'b1});

  assign busy     = (state_q != S_IDLE);
  assign mm_req   = (state_q == S_MRD_HI) || (state_q == S_MRD_LO) ||
                    (state_q == S_MWR_HI) || (state_q == S_MWR_LO);
  assign mm_we    = (state_q == S_MWR_HI) || (state_q == S_MWR_LO);
  assign mm_lo    = (state_q == S_MRD_LO) || (state_q == S_MWR_LO);
  assign dsp_req  = (state_q == S_DWR) || (state_q == S_DRD);
  assign dsp_we   = (state_q == S_DWR);
  assign cap_hi   = (state_q == S_MRD_HI) && mm_ack;
  assign cap_lo   = (state_q == S_MRD_LO) && mm_ack;
  assign cap_word = (state_q == S_DRD) && dsp_ack;
  assign step     = ((state_q == S_DWR) && dsp_ack) ||
                    ((state_q == S_MWR_LO) && mm_ack);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (launch)           state_d = first_st;
        else if (launch_zero) done_d  = 1'b1;
      end
      S_MRD_HI: if (mm_ack)  state_d = S_MRD_LO;
      S_MRD_LO: if (mm_ack)  state_d = S_DWR;
      S_DRD:    if (dsp_ack) state_d = S_MWR_HI;
      S_MWR_HI: if (mm_ack)  state_d = S_MWR_LO;
      S_DWR, S_MWR_LO: begin
        if (step) begin
          if (last_word) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = first_st;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import xfer_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               dsp_req,
  output logic               dsp_we,
  output logic               dsp_space,
  output logic [DSP_AW-1:0]  dsp_addr,
  output logic [WORD_W-1:0]  dsp_wdata,
  input  logic [WORD_W-1:0]  dsp_rdata,
  input  logic               dsp_ack,
  output logic               mm_req,
  output logic               mm_we,
  output logic [MAIN_AW-1:0] mm_addr,
  output logic [BYTE_W-1:0]  mm_wdata,
  input  logic [BYTE_W-1:0]  mm_rdata,
  input  logic               mm_ack,
  output logic               done
);

  logic               busy_w;
  logic               step_w;
  logic               launch_w;
  logic               launch_zero_w;
  logic               ctl_dir_w;
  logic               ctl_space_w;
  logic [MAIN_AW-1:0] main_addr_q;
  logic [LEN_W-1:0]   words_q;
  logic               mm_lo_w;
  logic               cap_hi_w;
  logic               cap_lo_w;
  logic               cap_word_w;

  xfer_dma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy_w),
    .step       (step_w),
    .reg_rdata  (reg_rdata),
    .ctl_dir    (ctl_dir_w),
    .ctl_space  (ctl_space_w),
    .dsp_addr   (dsp_addr),
    .main_addr  (main_addr_q),
    .words      (words_q),
    .launch     (launch_w),
    .launch_zero(launch_zero_w)
  );

  xfer_dma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch_w),
    .launch_zero(launch_zero_w),
    .ctl_dir    (ctl_dir_w),
    .words      (words_q),
    .dsp_ack    (dsp_ack),
    .mm_ack     (mm_ack),
    .busy       (busy_w),
    .step       (step_w),
    .done       (done),
    .dsp_req    (dsp_req),
    .dsp_we     (dsp_we),
    .mm_req     (mm_req),
    .mm_we      (mm_we),
    .mm_lo      (mm_lo_w),
    .cap_hi     (cap_hi_w),
    .cap_lo     (cap_lo_w),
    .cap_word   (cap_word_w)
  );

  xfer_dma_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi   (cap_hi_w),
    .cap_lo   (cap_lo_w),
    .cap_word (cap_word_w),
    .sel_lo   (mm_lo_w),
    .mm_rdata (mm_rdata),
    .dsp_rdata(dsp_rdata),
    .word_q   (dsp_wdata),
    .byte_out (mm_wdata)
  );

  assign dsp_space = ctl_space_w;
  assign mm_addr   = byte_addr(main_addr_q, mm_lo_w);

endmodule

// File: rtl/xfer_dma_chk.sv
module xfer_dma_chk
  import xfer_dma_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               launch,
  input logic               launch_zero,
  input logic               step,
  input logic               busy,
  input logic               done,
  input logic               mm_req,
  input logic               mm_ack,
  input logic               mm_we,
  input logic [MAIN_AW-1:0] mm_addr,
  input logic [BYTE_W-1:0]  mm_wdata,
  input logic               dsp_req,
  input logic               dsp_ack,
  input logic               dsp_we,
  input logic [DSP_AW-1:0]  dsp_addr,
  input logic [WORD_W-1:0]  dsp_wdata,
  input logic [MAIN_AW-1:0] main_addr,
  input logic               ctl_dir,
  input logic               ctl_space
);

  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req || dsp_req) |-> busy);

  assert_step_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (main_addr == $past(main_addr) + 32'd2));

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_zero |=> (done && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(main_addr) && $stable(dsp_addr) &&
                         $stable(ctl_dir) && $stable(ctl_space)));

  assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_req && dsp_req));

  assert_mm_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_ack) |=> (mm_req && $stable(mm_addr) && $stable(mm_we) &&
                             $stable(mm_wdata)));

  assert_dsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && !dsp_ack) |=> (dsp_req && $stable(dsp_addr) && $stable(dsp_we) &&
                               $stable(dsp_wdata)));

endmodule

bind xfer_dma xfer_dma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .launch     (launch_w),
  .launch_zero(launch_zero_w),
  .step       (step_w),
  .busy       (busy_w),
  .done       (done),
  .mm_req     (mm_req),
  .mm_ack     (mm_ack),
  .mm_we      (mm_we),
  .mm_addr    (mm_addr),
  .mm_wdata   (mm_wdata),
  .dsp_req    (dsp_req),
  .dsp_ack    (dsp_ack),
  .dsp_we     (dsp_we),
  .dsp_addr   (dsp_addr),
  .dsp_wdata  (dsp_wdata),
  .main_addr  (main_addr_q),
  .ctl_dir    (ctl_dir_w),
  .ctl_space  (ctl_space_w)
);

// File: tb/xfer_dma_tb.sv
`timescale 1ns/1ps
module xfer_dma_tb;

  localparam logic [15:0] A_CTL = 16'hFFC9;
  localparam logic [15:0] A_LEN = 16'hFFCB;
  localparam logic [15:0] A_DSP = 16'hFFCD;
  localparam logic [15:0] A_MHI = 16'hFFCE;
  localparam logic [15:0] A_MLO = 16'hFFCF;

  // {dir, space, latency[1:0], dsp addr[15:0], main addr[31:0], byte count[15:0]}
  localparam int NV = 6;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 16'h0010, 32'h0000_0020, 16'd8},
    {1'b0, 1'b1, 2'd1, 16'h0040, 32'h0000_0031, 16'd5},
    {1'b1, 1'b0, 2'd2, 16'h0080, 32'h0000_0060, 16'd6},
    {1'b1, 1'b1, 2'd0, 16'h00C0, 32'h0001_FFFE, 16'd7},
    {1'b0, 1'b0, 2'd2, 16'h00FE, 32'h0000_00F0, 16'd1},
    {1'b1, 1'b0, 2'd1, 16'h0005, 32'h1234_0090, 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        dsp_req, dsp_we, dsp_space;
  logic [15:0] dsp_addr, dsp_wdata;
  logic [15:0] dsp_rdata = 16'h0;
  logic        dsp_ack = 1'b0;
  logic        mm_req, mm_we;
  logic [31:0] mm_addr;
  logic [7:0]  mm_wdata;
  logic [7:0]  mm_rdata = 8'h0;
  logic        mm_ack = 1'b0;
  logic        done;

  logic [7:0]  mmem [256];
  logic [15:0] dmem [256];
  logic [15:0] imem [256];
  int lat = 0;
  int mwait = 0;
  int dwait = 0;
  int mm_acc = 0;
  int dsp_acc = 0;
  int done_cnt = 0;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xfer_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsp_req(dsp_req),
    .dsp_we(dsp_we), .dsp_space(dsp_space), .dsp_addr(dsp_addr),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_ack(dsp_ack),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_ack(mm_ack), .done(done)
  );

  always @(posedge clk) begin
    if (mm_req && !mm_ack) begin
      if (mwait >= lat) begin
        mm_ack <= 1'b1;
        mwait  <= 0;
        mm_acc++;
        if (mm_we) mmem[mm_addr[7:0]] <= mm_wdata;
        else       mm_rdata <= mmem[mm_addr[7:0]];
      end else begin
        mwait <= mwait + 1;
      end
    end else begin
      mm_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (dsp_req && !dsp_ack) begin
      if (dwait >= lat) begin
        dsp_ack <= 1'b1;
        dwait   <= 0;
        dsp_acc++;
        if (dsp_we) begin
          if (dsp_space) imem[dsp_addr[7:0]] <= dsp_wdata;
          else           dmem[dsp_addr[7:0]] <= dsp_wdata;
        end else begin
          dsp_rdata <= dsp_space ? imem[dsp_addr[7:0]] : dmem[dsp_addr[7:0]];
        end
      end else begin
        dwait <= dwait + 1;
      end
    end else begin
      dsp_ack <= 1'b0;
    end
  end

  always @(posedge clk) if (done) done_cnt++;

  function automatic logic [7:0] mpat(int i, int v);
    return 8'((i * 5 + v * 17 + 1) & 255);
  endfunction

  function automatic logic [15:0] dpat(int i, int v, bit sp);
    return 16'(((i & 255) * 257) ^ (v << 12) ^ (sp ? 16'h0F0F : 16'h0000));
  endfunction

  task automatic init_mem(int v);
    for (int i = 0; i < 256; i++) begin
      mmem[i] = mpat(i, v);
      dmem[i] = dpat(i, v, 1'b0);
      imem[i] = dpat(i, v, 1'b1);
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_done(output bit seen, output logic busy_at_done,
                           output logic done_after);
    logic [15:0] c;
    seen = 1'b0;
    busy_at_done = 1'b1;
    done_after = 1'b1;
    for (int n = 0; n < 4000 && !seen; n++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    rd(A_CTL, c);
    busy_at_done = c[2];
    @(negedge clk);
    done_after = done;
  endtask

  initial begin
    int seed_limit;
    seed_limit = 150000;
    repeat (seed_limit) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    bit seen;
    logic bsy, dn_after;
    init_mem(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_CTL, r); chk("R1", "ctl after reset", r, 0);
    rd(A_LEN, r); chk("R1", "count after reset", r, 0);
    rd(A_DSP, r); chk("R1", "dsp addr after reset", r, 0);
    rd(A_MHI, r); chk("R1", "main hi after reset", r, 0);
    rd(A_MLO, r); chk("R1", "main lo after reset", r, 0);
    chk("R1", "requests/done after reset", {mm_req, dsp_req, done}, 0);

    // R2: register map and read-only bits
    wr(A_CTL, 16'hFFFF); rd(A_CTL, r); chk("R2", "ctl readback masks", r, 16'h0003);
    wr(A_DSP, 16'hABCD); rd(A_DSP, r); chk("R2", "dsp addr readback", r, 16'hABCD);
    wr(A_MHI, 16'h1234); rd(A_MHI, r); chk("R2", "main hi readback", r, 16'h1234);
    wr(A_MLO, 16'h5678); rd(A_MLO, r); chk("R2", "main lo readback", r, 16'h5678);
    wr(16'hFFCA, 16'h7777); rd(16'hFFCA, r); chk("R2", "unmapped reads 0", r, 0);
    rd(A_DSP, r); chk("R2", "unmapped write no effect", r, 16'hABCD);

    // Vector table: R3..R7, R9
    for (int v = 0; v < NV; v++) begin
      logic        dir, sp;
      logic [15:0] d, len;
      logic [31:0] m, mend;
      int w, bad;
      dir = VEC[v][67]; sp = VEC[v][66]; lat = int'(VEC[v][65:64]);
      d = VEC[v][63:48]; m = VEC[v][47:16]; len = VEC[v][15:0];
      w = (int'(len) + 1) / 2;
      init_mem(v);
      wr(A_CTL, {14'd0, sp, dir});
      wr(A_DSP, d);
      wr(A_MHI, m[31:16]);
      wr(A_MLO, m[15:0]);
      mm_acc = 0; dsp_acc = 0; done_cnt = 0;
      wr(A_LEN, len);
      rd(A_CTL, r);
      chk("R3", $sformatf("vec%0d busy after launch", v), r[2], 1'b1);
      wait_done(seen, bsy, dn_after);
      chk("R9", $sformatf("vec%0d done seen, busy clear, one cycle", v),
          {seen, bsy, dn_after}, {1'b1, 1'b0, 1'b0});
      bad = 0;
      if (!dir) begin
        for (int k = 0; k < w; k++) begin
          logic [15:0] exp, act;
          exp = {mpat(int'(m[7:0]) + 2 * k, v), mpat(int'(m[7:0]) + 2 * k + 1, v)};
          act = sp ? imem[(int'(d) + k) & 255] : dmem[(int'(d) + k) & 255];
          if (act !== exp) bad++;
        end
        chk("R4", $sformatf("vec%0d words into dsp", v), bad, 0);
        chk("R6", $sformatf("vec%0d word past block untouched", v),
            sp ? imem[(int'(d) + w) & 255] : dmem[(int'(d) + w) & 255],
            dpat(int'(d) + w, v, sp));
        chk("R4", $sformatf("vec%0d other space untouched", v),
            sp ? dmem[int'(d) & 255] : imem[int'(d) & 255], dpat(int'(d), v, !sp));
      end else begin
        for (int k = 0; k < w; k++) begin
          logic [15:0] src;
          src = dpat(int'(d) + k, v, sp);
          if (mmem[(int'(m[7:0]) + 2 * k) & 255] !== src[15:8]) bad++;
          if (mmem[(int'(m[7:0]) + 2 * k + 1) & 255] !== src[7:0]) bad++;
        end
        chk("R5", $sformatf("vec%0d bytes into main", v), bad, 0);
        chk("R6", $sformatf("vec%0d byte past block untouched", v),
            mmem[(int'(m[7:0]) + 2 * w) & 255], mpat(int'(m[7:0]) + 2 * w, v));
      end
      chk("R6", $sformatf("vec%0d access counts", v), {mm_acc[15:0], dsp_acc[15:0]},
          {16'(2 * w), 16'(w)});
      mend = m + 32'(2 * w);
      rd(A_DSP, r); chk("R7", $sformatf("vec%0d dsp addr end", v), r, d + 16'(w));
      rd(A_MHI, r); chk("R7", $sformatf("vec%0d main hi end", v), r, mend[31:16]);
      rd(A_MLO, r); chk("R7", $sformatf("vec%0d main lo end", v), r, mend[15:0]);
      rd(A_LEN, r); chk("R7", $sformatf("vec%0d count end", v), r, 0);
      chk("R9", $sformatf("vec%0d single done pulse", v), done_cnt, 1);
    end

    // R8: zero length
    lat = 0; mm_acc = 0; dsp_acc = 0; done_cnt = 0;
    wr(A_LEN, 16'd0);
    chk("R8", "done right after zero write", done, 1'b1);
    rd(A_CTL, r); chk("R8", "busy stays 0", r[2], 1'b0);
    repeat (4) @(negedge clk);
    chk("R8", "no accesses, one done", {mm_acc[7:0], dsp_acc[7:0], done_cnt[7:0]},
        {8'd0, 8'd0, 8'd1});

    // R10: writes ignored while busy
    init_mem(7);
    lat = 2;
    wr(A_CTL, 16'h0000);
    wr(A_DSP, 16'h0020);
    wr(A_MHI, 16'h0000);
    wr(A_MLO, 16'h0040);
    mm_acc = 0; dsp_acc = 0; done_cnt = 0;
    wr(A_LEN, 16'd8);
    wr(A_CTL, 16'h0003);
    wr(A_DSP, 16'h0099);
    wr(A_MLO, 16'h0000);
    wr(A_LEN, 16'd2);
    rd(A_CTL, r); chk("R10", "ctl unchanged while busy", r, 16'h0004);
    wait_done(seen, bsy, dn_after);
    chk("R10", "done seen", seen, 1'b1);
    chk("R10", "access counts unchanged", {mm_acc[15:0], dsp_acc[15:0]}, {16'd8, 16'd4});
    rd(A_DSP, r); chk("R10", "dsp addr end", r, 16'h0024);
    rd(A_MLO, r); chk("R10", "main lo end", r, 16'h0048);
    chk("R10", "single done", done_cnt, 1);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 4; k++)
        if (dmem[16'h20 + k] !== {mpat(16'h40 + 2 * k, 7), mpat(16'h41 + 2 * k, 7)}) bad++;
      chk("R10", "data landed in data space", bad, 0);
      chk("R10", "instr space untouched", imem[16'h20], dpat(16'h20, 7, 1'b1));
    end

    // R11: request exclusivity is also watched by assertions
    chk("R11", "ports quiet after end", {mm_req, dsp_req}, 2'b00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule